// File: doc/BRIEF.md
# Incremental Conversion Sequencer with Slow Chopping

This block sequences one complete temperature conversion of a second-order switched-capacitor sigma-delta modulator. A start request first holds the integrators in reset for a fixed number of clocks. After that reset, the block steps the modulator through a fixed count of modulator cycles and then reports completion with a single-clock done pulse. Each modulator cycle is built from one or two integration sub-cycles. Every sub-cycle drives a sample phase, in which the amplifier sits in unity gain, and then an integrate phase. The two phases never overlap, and a dead gap follows each of them. Each main phase also has a copy whose falling edge comes a few clocks later.

The feedback bit of a cycle sets how much work that cycle does. A cycle with bit 0 integrates the difference voltage twice, so it runs two sub-cycles. A cycle with bit 1 integrates the base-emitter voltage once, so it runs one sub-cycle. The comparator is sampled at the close of the last integrate phase of each cycle. Its value is then committed as the next cycle's bit in the trailing gap, once the delayed phase copies have fallen.

A slow system chop completes two full periods over the conversion. Each chop flip reverses the input polarity, inverts the reported bitstream and swaps the integrator capacitors. Chop flips are committed on the same clock as the bit commit.

Top module: `csq_conv_seq`

## Requirements
- R1: After reset every output is low.
- R2: A start seen while idle raises `int_rst_o` for RST_TICKS (default 4) clocks. The clock after `int_rst_o` falls shows the first sample phase. While `int_rst_o` is high, `chop_o` and `bit_o` are 0.
- R3: Exactly N_CYC (default 400) modulator cycles run. `done_o` is then high for exactly one clock, after which the block is idle. A start during a conversion or during the done clock has no effect.
- R4: A cycle whose feedback bit is 0 runs two sub-cycles, and a cycle whose bit is 1 runs one. The bit of cycle 0 is 0.
- R5: Within a sub-cycle of 2*(PH+GAP) clocks (default 10), `samp_o` is high on ticks 0 to PH-1 (default 0 to 2) and `integ_o` is high on ticks PH+GAP to 2*PH+GAP-1 (default 5 to 7). The two never overlap.
- R6: `samp_dly_o` and `integ_dly_o` rise with their main phase and fall DLY clocks (default 1) after it.
- R7: `cmp_i` is sampled only on the last integrate tick of a cycle's last sub-cycle, and it becomes the feedback bit of the next cycle. `bit_o` equals the feedback bit XOR `chop_o`.
- R8: `bit_o` changes only at tick 2*PH+GAP+DLY (default 9) of a cycle's last sub-cycle, when all four phase outputs are low. `bit_stb_o` is high for exactly that clock at every cycle boundary, and not after the final cycle.
- R9: `chop_o` starts each conversion at 0. It toggles together with the bit commit at the ends of cycles N_CYC/4, N_CYC/2 and 3*N_CYC/4 (default cycles 100, 200 and 300, counting from 1), which gives two full periods.
- R10: All phase outputs are low while idle, while in integrator reset and during the done clock. `bit_o` and `chop_o` hold their final values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, honoured only while idle |
| cmp_i | input | 1 | Comparator decision from the modulator |
| samp_o | output | 1 | Sample phase (amplifier in unity gain) |
| samp_dly_o | output | 1 | Sample phase with delayed falling edge |
| integ_o | output | 1 | Integrate phase |
| integ_dly_o | output | 1 | Integrate phase with delayed falling edge |
| int_rst_o | output | 1 | Integrator reset |
| chop_o | output | 1 | System chop state |
| bit_o | output | 1 | Reported bitstream (feedback bit XOR chop) |
| bit_stb_o | output | 1 | One-clock mark of a bitstream update |
| done_o | output | 1 | One-clock end-of-conversion pulse |

## Verification
The bit commit and the chop flip fall on the same clock at the three chop boundaries. There, `bit_o` is the XOR of two values that both just changed. The stimulus therefore switches the comparator pattern exactly at cycles 99, 199 and 299, so that a correct commit and an inverted-but-stale value give different results. The comparator input carries its intended value only on the capture tick and the inverse on all other ticks, so a capture on the wrong tick is exposed by the reported bit and by the sub-cycle count of the next cycle. Start pulses arrive mid-conversion and on the done clock, and the clock-by-clock model checks that neither one disturbs the sequence.

// File: rtl/csq_pkg.sv
package csq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RST  = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } csq_state_e;

endpackage

// File: rtl/csq_phase_dec.sv
// Decodes the tick position inside one integration sub-cycle into the
// nonoverlapping phase controls and the tick markers used by the sequencer.
module csq_phase_dec #(
    parameter int PH_TICKS  = 3,
    parameter int GAP_TICKS = 2,
    parameter int DLY_TICKS = 1,
    parameter int TW        = 4
) (
    input  logic          active_i,
    input  logic [TW-1:0] tick_i,
    output logic          samp_o,
    output logic          samp_dly_o,
    output logic          integ_o,
    output logic          integ_dly_o,
    output logic          cap_tick_o,
    output logic          pre_upd_o,
    output logic          end_tick_o
);

    localparam int SUB_LEN   = 2 * (PH_TICKS + GAP_TICKS);
    localparam int INT_START = PH_TICKS + GAP_TICKS;
    localparam int INT_END   = 2 * PH_TICKS + GAP_TICKS;
    localparam int UPD_TICK  = INT_END + DLY_TICKS;

    localparam logic [TW-1:0] T_PH      = TW'(PH_TICKS);
    localparam logic [TW-1:0] T_INT_S   = TW'(INT_START);
    localparam logic [TW-1:0] T_INT_E   = TW'(INT_END);
    localparam logic [TW-1:0] T_CAP     = TW'(INT_END - 1);
    localparam logic [TW-1:0] T_PRE_UPD = TW'(UPD_TICK - 1);
    localparam logic [TW-1:0] T_LAST    = TW'(SUB_LEN - 1);

    logic in_samp;
    logic in_integ;

    always_comb begin
        in_samp  = active_i && (tick_i < T_PH);
        in_integ = active_i && (tick_i >= T_INT_S) && (tick_i < T_INT_E);
    end

    assign samp_o  = in_samp;
    assign integ_o = in_integ;

    generate
        if (DLY_TICKS == 0) begin : g_no_delay
            assign samp_dly_o  = in_samp;
            assign integ_dly_o = in_integ;
        end else begin : g_delay
            localparam logic [TW-1:0] T_SD_E = TW'(PH_TICKS + DLY_TICKS);
            localparam logic [TW-1:0] T_ID_E = TW'(INT_END + DLY_TICKS);
            assign samp_dly_o  = active_i && (tick_i < T_SD_E);
            assign integ_dly_o = active_i && (tick_i >= T_INT_S) && (tick_i < T_ID_E);
        end
    endgenerate

    assign cap_tick_o = active_i && (tick_i == T_CAP);
    assign pre_upd_o  = active_i && (tick_i == T_PRE_UPD);
    assign end_tick_o = active_i && (tick_i == T_LAST);

endmodule

// File: rtl/csq_chop_ctrl.sv
// Slow system chop: counts cycle boundaries and flips the chop state every
// SEG_CYCLES boundaries. Cleared when a conversion starts.
module csq_chop_ctrl #(
    parameter int SEG_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic bnd_i,
    output logic chop_o
);

    localparam int SW = (SEG_CYCLES > 1) ? $clog2(SEG_CYCLES) : 1;
    localparam logic [SW-1:0] SEG_LAST = SW'(SEG_CYCLES - 1);

    typedef struct packed {
        logic [SW-1:0] cnt;
        logic          chop;
    } chop_reg_t;

    chop_reg_t r_q;
    chop_reg_t r_d;

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d = '0;
        end else if (bnd_i) begin
            if (r_q.cnt == SEG_LAST) begin
                r_d.cnt  = '0;
                r_d.chop = ~r_q.chop;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign chop_o = r_q.chop;

    AST_CHOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !chop_o); // R9

endmodule

// File: rtl/csq_conv_seq.sv
// One-shot conversion sequencer: integrator reset, N_CYC modulator cycles
// with bit-dependent double integration, slow chop, done pulse.
module csq_conv_seq
    import csq_pkg::*;
#(
    parameter int N_CYC        = 400,
    parameter int CHOP_PERIODS = 2,
    parameter int RST_TICKS    = 4,
    parameter int PH_TICKS     = 3,
    parameter int GAP_TICKS    = 2,
    parameter int DLY_TICKS    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic cmp_i,
    output logic samp_o,
    output logic samp_dly_o,
    output logic integ_o,
    output logic integ_dly_o,
    output logic int_rst_o,
    output logic chop_o,
    output logic bit_o,
    output logic bit_stb_o,
    output logic done_o
);

    localparam int SUB_LEN    = 2 * (PH_TICKS + GAP_TICKS);
    localparam int TMAX       = (SUB_LEN > RST_TICKS) ? SUB_LEN : RST_TICKS;
    localparam int TW         = $clog2(TMAX + 1);
    localparam int CW         = (N_CYC > 1) ? $clog2(N_CYC) : 1;
    localparam int SEG_CYCLES = N_CYC / (2 * CHOP_PERIODS);

    localparam logic [TW-1:0] RST_LAST = TW'(RST_TICKS - 1);
    localparam logic [CW-1:0] CYC_LAST = CW'(N_CYC - 1);

    typedef struct packed {
        csq_state_e    st;
        logic [TW-1:0] tick;
        logic          sub;
        logic          dbl;
        logic [CW-1:0] cyc;
        logic          cap;
        logic          fb;
        logic          stb;
    } seq_reg_t;

    seq_reg_t r_q;
    seq_reg_t r_d;

    logic run;
    logic cap_tick;
    logic pre_upd;
    logic end_tick;
    logic last_sub;
    logic last_cyc;
    logic chop_clear;
    logic chop_bnd;
    logic chop_q;

    assign run = (r_q.st == ST_RUN);

    csq_phase_dec #(
        .PH_TICKS  (PH_TICKS),
        .GAP_TICKS (GAP_TICKS),
        .DLY_TICKS (DLY_TICKS),
        .TW        (TW)
    ) u_phase (
        .active_i    (run),
        .tick_i      (r_q.tick),
        .samp_o      (samp_o),
        .samp_dly_o  (samp_dly_o),
        .integ_o     (integ_o),
        .integ_dly_o (integ_dly_o),
        .cap_tick_o  (cap_tick),
        .pre_upd_o   (pre_upd),
        .end_tick_o  (end_tick)
    );

    csq_chop_ctrl #(
        .SEG_CYCLES (SEG_CYCLES)
    ) u_chop (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (chop_clear),
        .bnd_i   (chop_bnd),
        .chop_o  (chop_q)
    );

    always_comb begin
        last_sub = !r_q.dbl || r_q.sub;
        last_cyc = (r_q.cyc == CYC_LAST);
    end

    always_comb begin
        r_d        = r_q;
        r_d.stb    = 1'b0;
        chop_clear = 1'b0;
        chop_bnd   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st     = ST_RST;
                    r_d.tick   = '0;
                    r_d.fb     = 1'b0;
                    chop_clear = 1'b1;
                end
            end
            ST_RST: begin
                if (r_q.tick == RST_LAST) begin
                    r_d.st   = ST_RUN;
                    r_d.tick = '0;
                    r_d.sub  = 1'b0;
                    r_d.dbl  = 1'b1;
                    r_d.cyc  = '0;
                    r_d.cap  = 1'b0;
                    r_d.fb   = 1'b0;
                end else begin
                    r_d.tick = r_q.tick + 1'b1;
                end
            end
            ST_RUN: begin
                if (cap_tick && last_sub) begin
                    r_d.cap = cmp_i;
                end
                if (pre_upd && last_sub && !last_cyc) begin
                    r_d.fb   = r_q.cap;
                    r_d.stb  = 1'b1;
                    chop_bnd = 1'b1;
                end
                if (end_tick) begin
                    r_d.tick = '0;
                    if (!last_sub) begin
                        r_d.sub = 1'b1;
                    end else begin
                        r_d.sub = 1'b0;
                        if (last_cyc) begin
                            r_d.st = ST_DONE;
                        end else begin
                            r_d.cyc = r_q.cyc + 1'b1;
                            r_d.dbl = !r_q.fb;
                        end
                    end
                end else begin
                    r_d.tick = r_q.tick + 1'b1;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign int_rst_o = (r_q.st == ST_RST);
    assign done_o    = (r_q.st == ST_DONE);
    assign chop_o    = chop_q;
    assign bit_o     = r_q.fb ^ chop_q;
    assign bit_stb_o = r_q.stb;

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_dly_o && integ_dly_o)); // R5

    AST_SAMP_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(samp_o) |-> samp_dly_o); // R6

    AST_INTEG_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(integ_o) |-> integ_dly_o); // R6

    AST_BIT_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_o) |-> !(samp_dly_o || integ_dly_o)); // R8

    AST_STB_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb_o |-> !(samp_dly_o || integ_dly_o || samp_o || integ_o)); // R8

    AST_CHOP_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(chop_o) && !int_rst_o) |-> bit_stb_o); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3

    AST_QUIET_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rst_o || done_o) |-> !(samp_dly_o || integ_dly_o)); // R10

    AST_RST_TO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_rst_o) |-> samp_o); // R2

endmodule

// File: tb/csq_conv_seq_test.sv
module csq_conv_seq_test;

    localparam int N     = 400;
    localparam int SEG   = 100;
    localparam int RSTT  = 4;
    localparam int PH    = 3;
    localparam int GAP   = 2;
    localparam int DLY   = 1;
    localparam int SUBL  = 2 * (PH + GAP);
    localparam int CAPT  = 2 * PH + GAP - 1;
    localparam int UPDT  = 2 * PH + GAP + DLY;

    typedef struct packed {
        logic start;
        logic cmp;
        logic samp, sd, integ, id, rst, chop, bitv, stb, done;
    } ent_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic cmp_i = 1'b0;
    logic samp_o, samp_dly_o, integ_o, integ_dly_o, int_rst_o;
    logic chop_o, bit_o, bit_stb_o, done_o;

    int vectors = 0;
    int miscompares = 0;
    ent_t q[$];
    logic m_fb = 1'b0;
    logic m_chop = 1'b0;

    always #4 clk = ~clk;

    csq_conv_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .samp_o(samp_o), .samp_dly_o(samp_dly_o), .integ_o(integ_o),
        .integ_dly_o(integ_dly_o), .int_rst_o(int_rst_o), .chop_o(chop_o),
        .bit_o(bit_o), .bit_stb_o(bit_stb_o), .done_o(done_o)
    );

    function automatic logic pat(input int pid, input int k);
        case (pid)
            0: return (k % 3 == 0);
            1: return (k < 99) ? 1'b1 : ((k < 199) ? 1'b0 : ((k < 299) ? 1'b1 : 1'b0));
            2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic fchk(input string req, input string nm, input logic act, input logic exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic cmp_all(input ent_t e);
        vectors++;
        fchk("R5", "samp_o", samp_o, e.samp);          // R4 sub-cycle count shows here
        fchk("R6", "samp_dly_o", samp_dly_o, e.sd);
        fchk("R4", "integ_o", integ_o, e.integ);
        fchk("R6", "integ_dly_o", integ_dly_o, e.id);
        fchk("R2", "int_rst_o", int_rst_o, e.rst);
        fchk("R9", "chop_o", chop_o, e.chop);
        fchk("R7", "bit_o", bit_o, e.bitv);
        fchk("R8", "bit_stb_o", bit_stb_o, e.stb);
        fchk("R3", "done_o", done_o, e.done);
    endtask

    // Behavioural expectation of one full conversion, one entry per clock.
    task automatic build(input int pid, input int busy_at, input bit start_on_done);
        ent_t e;
        int idx = 0;
        m_fb = 1'b0;
        m_chop = 1'b0;
        for (int i = 0; i < RSTT; i++) begin
            e = '0;
            e.rst = 1'b1;
            q.push_back(e);
            idx++;
        end
        for (int k = 0; k < N; k++) begin
            int nsub = m_fb ? 1 : 2;
            for (int s = 0; s < nsub; s++) begin
                for (int t = 0; t < SUBL; t++) begin
                    bit last = (s == nsub - 1);
                    e = '0;
                    e.samp  = (t < PH);
                    e.sd    = (t < PH + DLY);
                    e.integ = (t >= PH + GAP) && (t < 2 * PH + GAP);
                    e.id    = (t >= PH + GAP) && (t < 2 * PH + GAP + DLY);
                    e.cmp   = (last && t == CAPT) ? pat(pid, k) : ~pat(pid, k);
                    if (last && t == UPDT && k < N - 1) begin
                        m_fb = pat(pid, k);
                        if ((k + 1) % SEG == 0) m_chop = ~m_chop;
                        e.stb = 1'b1;
                    end
                    e.chop  = m_chop;
                    e.bitv  = m_fb ^ m_chop;
                    e.start = (idx == busy_at);
                    q.push_back(e);
                    idx++;
                end
            end
        end
        e = '0;
        e.done  = 1'b1;
        e.chop  = m_chop;
        e.bitv  = m_fb ^ m_chop;
        e.start = start_on_done;
        q.push_back(e);
        for (int i = 0; i < 3; i++) begin
            e = '0;
            e.chop = m_chop;
            e.bitv = m_fb ^ m_chop;
            q.push_back(e);
        end
    endtask

    task automatic run_conv(input int pid, input int busy_at, input bit start_on_done);
        ent_t e;
        build(pid, busy_at, start_on_done);
        @(negedge clk);
        start_i = 1'b1;
        while (q.size() > 0) begin
            e = q.pop_front();
            @(negedge clk);
            start_i = e.start;
            cmp_i   = e.cmp;
            cmp_all(e);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        ent_t z;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet after reset, R10 idle stays quiet
        z = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cmp_all(z);
        end
        run_conv(0, 777, 1'b1);   // R3 start mid-run and on done ignored
        run_conv(1, -1, 1'b0);    // R9 pattern flips with chop boundaries
        run_conv(2, 50, 1'b0);    // R4 all single sub-cycles
        run_conv(3, -1, 1'b1);    // R4 all double sub-cycles
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule